// File: doc/BRIEF.md
# Periodic Acquisition Trigger Controller

This block decides when a position-encoder transaction begins on each of several independent channels. Every channel has its own trigger mode. In host mode a one-cycle command pulse from software starts a transaction. In compare mode a per-channel timer counts up to a programmed limit, wraps to zero and raises an event, which gives fixed-rate sampling. In capture mode a rising edge on an asynchronous external pulse input is the event, after a two-flop synchronizer.

A periodic event sets a sticky pending flag. On the next cycle in which the channel is idle, the controller clears the flag and issues a one-cycle start pulse to the transaction sequencer. The channel then stays busy until the sequencer returns its done pulse. At that point the channel raises a one-cycle completion interrupt. Any trigger that arrives while the channel is busy or already pending is refused and reported as an overrun. This is how a trigger period shorter than one transaction becomes visible. When a channel is switched back to host mode, the transaction in flight completes normally and no further periodic starts occur.

Top module: `acq_trigger_ctrl`

## Requirements
- R1: After reset every output of every channel (start, busy, pending, interrupt, overrun) is 0.
- R2: In host mode (mode code 2'b00), a host command pulse in cycle k on an idle channel drives that channel's start high for exactly cycle k+1. Busy is high from cycle k+1.
- R3: In compare mode (mode code 2'b01) with limit C, the timer produces an event every C+1 cycles. Each accepted event in cycle e gives a start in cycle e+2, so accepted starts are spaced C+1 cycles apart.
- R4: Outside compare mode the timer is held at zero. When the mode is set to compare in cycle k, the first event falls in cycle k+C and the first start in cycle k+C+2.
- R5: In capture mode (mode code 2'b10), a rising edge of the capture input first seen in cycle k gives exactly one start in cycle k+4, whatever the pulse width. A falling edge or a held-high level starts nothing.
- R6: A periodic event on an idle channel makes pending high for exactly one cycle (e+1), and pending is low in the cycle of the resulting start.
- R7: A trigger (periodic event or host command) that arrives while the channel is busy or pending starts nothing. It makes overrun high for one cycle in the next cycle.
- R8: A done pulse in cycle d on a busy channel clears busy and makes the interrupt high for exactly cycle d+1. A done pulse on an idle channel has no effect.
- R9: A switch to host mode during a periodic transaction lets that transaction finish with its interrupt. No periodic start follows, and pending stays low while in host mode.
- R10: Channels are independent: the mode, limit, capture input and done of one channel never change another channel's outputs.
- R11: A host command is ignored in compare and capture modes. Mode code 2'b11 behaves exactly like host mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2*NUM_CH | Per-channel mode code, channel c in bits [2c+1:2c] |
| cmp_val_i | input | TIMER_W*NUM_CH | Per-channel compare limit C, channel c in bits [TIMER_W*c +: TIMER_W] |
| host_cmd_i | input | NUM_CH | Per-channel host command pulse |
| cap_in_i | input | NUM_CH | Per-channel asynchronous capture input |
| done_i | input | NUM_CH | Per-channel transaction done pulse from the sequencer |
| start_o | output | NUM_CH | Per-channel one-cycle transaction start |
| busy_o | output | NUM_CH | Per-channel transaction in flight |
| pend_o | output | NUM_CH | Per-channel sticky event status awaiting service |
| irq_o | output | NUM_CH | Per-channel one-cycle completion interrupt |
| overrun_o | output | NUM_CH | Per-channel one-cycle refused-trigger flag |

## Verification
The hardest situation to reach from the ports is a periodic event that lands exactly while the channel is busy or while an earlier event is still pending. The bench reaches it by pairing a transaction responder of fixed latency with a compare limit of 1. This forces a repeating pattern in which two events out of three are refused, and it checks the resulting six-cycle start spacing. A sweep of compare limits above the transaction length then checks exact spacing, first-start latency and the absence of overruns. A mode switch issued in the very cycle of a start checks that the transaction still drains cleanly.

// File: rtl/acq_trig_pkg.sv
// Package: shared mode encoding for the acquisition trigger controller.
// Assumes: two-bit mode field per channel; the code 2'b11 is treated as host.
package acq_trig_pkg;

    typedef enum logic [1:0] {
        MODE_HOST = 2'b00,
        MODE_CMP  = 2'b01,
        MODE_CAP  = 2'b10,
        MODE_RSVD = 2'b11
    } trig_mode_e;

endpackage

// File: rtl/acq_chan_timer.sv
// Module: per-channel compare timer. It counts up while enabled, raises a
// match when the count reaches the limit and wraps to zero on that cycle.
// Assumes: when disabled the count is held at zero. If the limit is lowered
// below the present count, the count wraps at once (>= compare).
module acq_chan_timer #(
    parameter int TIMER_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic [TIMER_W-1:0] limit_i,
    output logic               match_o
);

    logic [TIMER_W-1:0] cnt_q;
    logic               at_limit;

    // Detect that the count has reached (or passed) the programmed limit.
    assign at_limit = (cnt_q >= limit_i);
    assign match_o  = run_i && at_limit;

    // Count while running, wrap at the limit, hold at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || at_limit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/acq_cap_edge.sv
// Module: capture input conditioner. It passes an asynchronous input through a
// SYNC_STAGES-flop synchronizer and flags a rising edge for one cycle.
// Assumes: input pulses last at least one clock period.
module acq_cap_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Shift the raw input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], async_i};
        end
    end

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise_o = sync_q[SYNC_STAGES-1] && !last_q;

endmodule

// File: rtl/acq_chan_seq.sv
// Module: per-channel trigger sequencer. It latches periodic events into a
// sticky pending flag, converts pending or a host command into a one-cycle
// start, tracks busy until done, and flags completion and refused triggers.
// Assumes: evt_i is already qualified by the mode; done_i is a pulse.
module acq_chan_seq
    import acq_trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  trig_mode_e mode_i,
    input  logic       evt_i,
    input  logic       host_cmd_i,
    input  logic       done_i,
    output logic       start_o,
    output logic       busy_o,
    output logic       pend_o,
    output logic       irq_o,
    output logic       overrun_o
);

    logic periodic;
    logic host_trig;

    // Classify the mode: compare and capture are periodic, others act as host.
    assign periodic  = (mode_i == MODE_CMP) || (mode_i == MODE_CAP);
    assign host_trig = !periodic && host_cmd_i;

    // Start, busy, pending, completion and refusal bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_o   <= 1'b0;
            busy_o    <= 1'b0;
            pend_o    <= 1'b0;
            irq_o     <= 1'b0;
            overrun_o <= 1'b0;
        end else begin
            start_o   <= 1'b0;
            irq_o     <= 1'b0;
            overrun_o <= 1'b0;
            if (busy_o && done_i) begin
                busy_o <= 1'b0;
                irq_o  <= 1'b1;
            end
            if (!periodic) begin
                pend_o <= 1'b0;
                if (host_trig) begin
                    if (busy_o) begin
                        overrun_o <= 1'b1;
                    end else begin
                        start_o <= 1'b1;
                        busy_o  <= 1'b1;
                    end
                end
            end else begin
                if (pend_o && !busy_o) begin
                    pend_o  <= 1'b0;
                    start_o <= 1'b1;
                    busy_o  <= 1'b1;
                end
                if (evt_i) begin
                    if (busy_o || pend_o) begin
                        overrun_o <= 1'b1;
                    end else begin
                        pend_o <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/acq_trigger_ctrl.sv
// Module: top of the acquisition trigger controller. It instantiates one
// timer, one capture conditioner and one sequencer per channel, and selects
// the event source from each channel's mode.
// Assumes: per-channel fields are packed side by side in the flat ports.
module acq_trigger_ctrl
    import acq_trig_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int TIMER_W     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [2*NUM_CH-1:0]         mode_i,
    input  logic [TIMER_W*NUM_CH-1:0]   cmp_val_i,
    input  logic [NUM_CH-1:0]           host_cmd_i,
    input  logic [NUM_CH-1:0]           cap_in_i,
    input  logic [NUM_CH-1:0]           done_i,
    output logic [NUM_CH-1:0]           start_o,
    output logic [NUM_CH-1:0]           busy_o,
    output logic [NUM_CH-1:0]           pend_o,
    output logic [NUM_CH-1:0]           irq_o,
    output logic [NUM_CH-1:0]           overrun_o
);

    localparam int MODE_W = 2;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        trig_mode_e mode_c;
        logic       tmr_match;
        logic       cap_rise;
        logic       evt_c;

        assign mode_c = trig_mode_e'(mode_i[MODE_W*c +: MODE_W]);

        acq_chan_timer #(.TIMER_W(TIMER_W)) tmr_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .run_i   (mode_c == MODE_CMP),
            .limit_i (cmp_val_i[TIMER_W*c +: TIMER_W]),
            .match_o (tmr_match)
        );

        acq_cap_edge #(.SYNC_STAGES(SYNC_STAGES)) cap_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (cap_in_i[c]),
            .rise_o  (cap_rise)
        );

        // Pick the event source that matches the channel mode.
        always_comb begin
            unique case (mode_c)
                MODE_CMP: evt_c = tmr_match;
                MODE_CAP: evt_c = cap_rise;
                default:  evt_c = 1'b0;
            endcase
        end

        acq_chan_seq seq_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .mode_i     (mode_c),
            .evt_i      (evt_c),
            .host_cmd_i (host_cmd_i[c]),
            .done_i     (done_i[c]),
            .start_o    (start_o[c]),
            .busy_o     (busy_o[c]),
            .pend_o     (pend_o[c]),
            .irq_o      (irq_o[c]),
            .overrun_o  (overrun_o[c])
        );
    end

endmodule

// File: rtl/acq_trig_checker.sv
// Module: protocol checker for the acquisition trigger controller, bound to
// the top. Assumes the same flat per-channel packing as the top.
module acq_trig_checker #(
    parameter int NUM_CH  = 2,
    parameter int TIMER_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [2*NUM_CH-1:0]       mode_i,
    input logic [TIMER_W*NUM_CH-1:0] cmp_val_i,
    input logic [NUM_CH-1:0]         host_cmd_i,
    input logic [NUM_CH-1:0]         cap_in_i,
    input logic [NUM_CH-1:0]         done_i,
    input logic [NUM_CH-1:0]         start_o,
    input logic [NUM_CH-1:0]         busy_o,
    input logic [NUM_CH-1:0]         pend_o,
    input logic [NUM_CH-1:0]         irq_o,
    input logic [NUM_CH-1:0]         overrun_o
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R2: a start lasts one cycle and coincides with busy.
        assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
            start_o[c] |=> !start_o[c]);
        assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
            start_o[c] |-> busy_o[c]);
        // R6: a start follows either a pending event or a host command.
        assert_start_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
            start_o[c] |-> ($past(pend_o[c]) || $past(host_cmd_i[c])));
        // R6: pending on an idle channel clears after one cycle.
        assert_pend_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_o[c] && !busy_o[c]) |=> !pend_o[c]);
        // R7: an overrun only follows a busy or pending channel.
        assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
            overrun_o[c] |-> $past(busy_o[c] || pend_o[c]));
        // R8: the interrupt follows a done seen while busy, and busy has dropped.
        assert_irq_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[c] |-> ($past(done_i[c]) && $past(busy_o[c]) && !busy_o[c]));
        // R9: in host-like modes the pending flag stays low.
        assert_no_pend_host_R9: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(mode_i[2*c+1]) == $past(mode_i[2*c])) |-> !pend_o[c]);
    end

endmodule

bind acq_trigger_ctrl acq_trig_checker #(.NUM_CH(NUM_CH), .TIMER_W(TIMER_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .cmp_val_i  (cmp_val_i),
    .host_cmd_i (host_cmd_i),
    .cap_in_i   (cap_in_i),
    .done_i     (done_i),
    .start_o    (start_o),
    .busy_o     (busy_o),
    .pend_o     (pend_o),
    .irq_o      (irq_o),
    .overrun_o  (overrun_o)
);

// File: tb/acq_trigger_ctrl_tb_top.sv
`timescale 1ns/1ps
module acq_trigger_ctrl_tb_top;

    localparam int NCH = 2;
    localparam int TW  = 8;
    localparam int LAT = 2;  // responder: done sampled LAT cycles after start

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2*NCH-1:0]  mode = '0;
    logic [TW*NCH-1:0] cmp = '0;
    logic [NCH-1:0]  host_cmd = '0;
    logic [NCH-1:0]  cap_in = '0;
    logic [NCH-1:0]  done;
    logic [NCH-1:0]  force_done = '0;
    logic [NCH-1:0]  start_o, busy_o, pend_o, irq_o, overrun_o;
    logic [7:0]      sr [NCH];

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int n_start [NCH];
    int n_irq [NCH];
    int n_ov [NCH];
    int last_start [NCH];
    int exp_iv [NCH];
    bit iv_chk [NCH];

    always #4 clk = ~clk;

    acq_trigger_ctrl #(.NUM_CH(NCH), .TIMER_W(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .cmp_val_i(cmp),
        .host_cmd_i(host_cmd), .cap_in_i(cap_in), .done_i(done),
        .start_o(start_o), .busy_o(busy_o), .pend_o(pend_o),
        .irq_o(irq_o), .overrun_o(overrun_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(posedge clk) cyc++;

    // Transaction responder: done returned LAT cycles after each start.
    always @(negedge clk) begin
        for (int c = 0; c < NCH; c++) sr[c] <= {sr[c][6:0], start_o[c]};
    end
    always_comb begin
        for (int c = 0; c < NCH; c++) done[c] = sr[c][LAT] | force_done[c];
    end

    // Output monitor: counts events and checks start spacing (R3).
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                if (start_o[c]) begin
                    n_start[c]++;
                    if (iv_chk[c] && n_start[c] > 1)
                        chk(cyc - last_start[c] == exp_iv[c], "R3 spacing", cyc - last_start[c], exp_iv[c]);
                    last_start[c] = cyc;
                end
                if (irq_o[c]) n_irq[c]++;
                if (overrun_o[c]) n_ov[c]++;
            end
        end
    end

    task automatic clr_counts();
        for (int c = 0; c < NCH; c++) begin
            n_start[c] = 0; n_irq[c] = 0; n_ov[c] = 0; last_start[c] = -1; iv_chk[c] = 0;
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int k;
        for (int c = 0; c < NCH; c++) sr[c] = '0;
        clr_counts();
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        // R1: reset state
        chk({start_o, busy_o, pend_o, irq_o, overrun_o} == '0, "R1 reset outputs",
            {start_o, busy_o, pend_o, irq_o, overrun_o}, 0);

        // R2, R8: host command on channel 0
        clr_counts();
        k = cyc; host_cmd[0] = 1'b1;
        wait_cyc(1); host_cmd[0] = 1'b0;
        chk(start_o[0] && busy_o[0], "R2 start after host cmd", {start_o[0], busy_o[0]}, 3);
        wait_cyc(1);
        chk(!start_o[0], "R2 start one cycle", start_o[0], 0);
        wait_cyc(1);
        chk(busy_o[0] && !irq_o[0], "R8 busy until done", {busy_o[0], irq_o[0]}, 2);
        wait_cyc(1);
        chk(!busy_o[0] && irq_o[0], "R8 irq after done", {busy_o[0], irq_o[0]}, 1);
        wait_cyc(1);
        chk(!irq_o[0], "R8 irq one cycle", irq_o[0], 0);

        // R7: host command while busy is refused
        clr_counts();
        host_cmd[0] = 1'b1; wait_cyc(1); host_cmd[0] = 1'b0;
        wait_cyc(1);
        host_cmd[0] = 1'b1; wait_cyc(1); host_cmd[0] = 1'b0;
        chk(overrun_o[0] && !start_o[0], "R7 host overrun", {overrun_o[0], start_o[0]}, 2);
        wait_cyc(8);
        chk(n_start[0] == 1 && n_irq[0] == 1, "R7 single transaction", n_start[0], 1);

        // R8: done on idle channel ignored
        clr_counts();
        force_done[0] = 1'b1; wait_cyc(1); force_done[0] = 1'b0;
        wait_cyc(3);
        chk(n_irq[0] == 0 && !busy_o[0], "R8 idle done ignored", n_irq[0], 0);

        // R3, R4, R6, R9: compare sweep with clean spacing
        for (int cv = 4; cv <= 9; cv++) begin
            clr_counts();
            cmp[TW-1:0] = TW'(cv);
            exp_iv[0] = cv + 1; iv_chk[0] = 1;
            k = cyc; mode[1:0] = 2'b01;
            wait_cyc(cv + 1);
            chk(pend_o[0] && !start_o[0], "R6 pending before start", {pend_o[0], start_o[0]}, 2);
            wait_cyc(1);
            chk(start_o[0] && !pend_o[0], "R4 first start latency", cyc - k, cv + 2);
            wait_cyc(4 * (cv + 1));
            chk(start_o[0], "R3 fifth start", start_o[0], 1);
            mode[1:0] = 2'b00; iv_chk[0] = 0;
            wait_cyc(10);
            chk(n_start[0] == 5, "R9 no start after switch", n_start[0], 5);
            chk(n_irq[0] == 5, "R9 last transaction completes", n_irq[0], 5);
            chk(n_ov[0] == 0, "R7 no overrun when period long", n_ov[0], 0);
            chk(n_start[1] == 0, "R10 other channel quiet", n_start[1], 0);
        end

        // R7: compare limit 1, events land while busy or pending
        clr_counts();
        cmp[TW-1:0] = TW'(1);
        exp_iv[0] = 6; iv_chk[0] = 1;
        mode[1:0] = 2'b01;
        wait_cyc(40);
        mode[1:0] = 2'b00; iv_chk[0] = 0;
        wait_cyc(10);
        chk(n_ov[0] >= 2 * (n_start[0] - 1), "R7 overrun count", n_ov[0], 2 * (n_start[0] - 1));
        chk(n_irq[0] == n_start[0], "R7 no second transaction", n_irq[0], n_start[0]);

        // R5, R10: capture on channel 1, compare running on channel 0
        clr_counts();
        cmp[TW-1:0] = TW'(6);
        exp_iv[0] = 7; iv_chk[0] = 1;
        mode[1:0] = 2'b01; mode[3:2] = 2'b10;
        wait_cyc(3);
        for (int w = 1; w <= 3; w++) begin
            k = cyc; cap_in[1] = 1'b1;
            wait_cyc(w); cap_in[1] = 1'b0;
            wait_cyc(14 - w);
            chk(n_start[1] == w, "R5 one start per rising edge", n_start[1], w);
            chk(last_start[1] == k + 4, "R5 capture latency", last_start[1] - k, 4);
        end
        chk(n_start[0] > 0 && n_ov[0] == 0, "R10 channel 0 unaffected", n_ov[0], 0);
        mode[1:0] = 2'b00; iv_chk[0] = 0;

        // R11: host command ignored in capture mode; code 2'b11 acts as host
        clr_counts();
        host_cmd[1] = 1'b1; wait_cyc(1); host_cmd[1] = 1'b0;
        wait_cyc(6);
        chk(n_start[1] == 0 && !busy_o[1], "R11 host cmd ignored in capture", n_start[1], 0);
        mode[3:2] = 2'b11;
        host_cmd[1] = 1'b1; wait_cyc(1); host_cmd[1] = 1'b0;
        chk(start_o[1], "R11 reserved code acts as host", start_o[1], 1);
        wait_cyc(6);
        chk(n_irq[1] == 1 && n_start[0] == 0, "R10 R11 isolated completion", n_irq[1], 1);

        finish_run();
    end

endmodule